// File: doc/BRIEF.md
# Lane Broadcast Unit for Replicating Vector Loads

This block takes one element that has already been fetched from memory and spreads it across a 128-bit vector register value. The element may be 1, 2, 4 or 8 bytes wide, as a 2-bit size code selects. The low 64 bits of the result always hold the element repeated in every lane of that width. A quad-width flag decides the upper 64 bits. When the flag is set, they hold a second copy of the low half. When it is clear, they are all zero.

The result must match, bit for bit, the product of the masked element and a constant that has a one at the bottom bit of every lane. The implementation builds it by concatenation, so no multiplier is needed. Any element bits above the selected width are discarded before replication.

Inputs and outputs each use a valid/ready handshake. An accepted element produces a registered result one cycle later. That result stays on the output until the consumer takes it. A new element is accepted in the same cycle that the previous result is taken, so the block sustains one element per clock.

Top module: `lane_bcast`

## Requirements
- R1: After reset, `outValid` is 0 and `inReady` is 1.
- R2: With `inScale` = 0 (1-byte lanes), `outData[63:0]` equals `inElem[7:0]` multiplied by 0x0101010101010101.
- R3: With `inScale` = 1 (2-byte lanes), `outData[63:0]` equals `inElem[15:0]` multiplied by 0x0001000100010001.
- R4: With `inScale` = 2 (4-byte lanes), `outData[63:0]` equals `inElem[31:0]` multiplied by 0x0000000100000001.
- R5: With `inScale` = 3 (8-byte lane), `outData[63:0]` equals `inElem` unchanged.
- R6: Bits of `inElem` above the width selected by `inScale` have no effect on `outData`.
- R7: When `inQuad` = 1, `outData[127:64]` equals `outData[63:0]`.
- R8: When `inQuad` = 0, `outData[127:64]` is zero.
- R9: An element accepted at a clock edge (`inValid` and `inReady` both high) makes `outValid` high after that edge, with the matching result on `outData`.
- R10: While `outValid` is 1 and `outReady` is 0, `outValid` stays 1, `outData` does not change, and `inReady` is 0.
- R11: While `outReady` is held at 1, one element is accepted on every clock edge with no stall cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Element offered |
| inReady | output | 1 | Block can take an element this cycle |
| inElem | input | 64 | Loaded element; only its low bytes are used |
| inScale | input | 2 | Element width code: 0=1 byte, 1=2, 2=4, 3=8 |
| inQuad | input | 1 | 1: fill both 64-bit halves; 0: upper half zero |
| outValid | output | 1 | Result available |
| outReady | input | 1 | Consumer takes the result this cycle |
| outData | output | 128 | Replicated vector register value |

## Verification
The assertions take for granted that `inElem`, `inScale` and `inQuad` carry known values whenever `inValid` is high. They also take for granted that reset is held for at least one edge before any traffic. Every 2-bit size code is a legal encoding, so the properties place no other limit on the inputs. The bench changes inputs only just after a rising edge. It keeps `inValid` high with the same element until the block accepts it. It also pulls `outReady` low in a pseudo-random pattern, so both the stall path and the stream path get exercised.

// File: rtl/lane_bcast_pkg.sv
package lane_bcast_pkg;

  // Strobes from the handshake controller to the datapath.
  typedef struct packed {
    logic capture;   // latch a new replicated result this edge
  } bcastCtrl_t;

endpackage

// File: rtl/lane_bcast_ctrl.sv
module lane_bcast_ctrl
  import lane_bcast_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  output logic       inReady,
  output logic       outValid,
  input  logic       outReady,
  output bcastCtrl_t ctrl
);

  logic validQ;

  // A slot is free when nothing is held or the held result leaves this cycle.
  assign inReady      = !validQ || outReady;
  assign ctrl.capture = inValid && inReady;
  assign outValid     = validQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= 1'b0;
    end else if (ctrl.capture) begin
      validQ <= 1'b1;
    end else if (outReady) begin
      validQ <= 1'b0;
    end
  end

  assert_accept_gives_valid_R9: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> outValid);

  assert_stall_keeps_valid_R10: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid);

  assert_stall_blocks_input_R10: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |-> !inReady);

  assert_free_when_draining_R11: assert property (@(posedge clk) disable iff (!rstN)
    outReady |-> inReady);

endmodule

// File: rtl/lane_bcast_dp.sv
module lane_bcast_dp
  import lane_bcast_pkg::*;
#(
  parameter int MIN_BITS = 8,
  parameter int SCALE_W  = 2,
  parameter int LANE_BITS = MIN_BITS << ((1 << SCALE_W) - 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  bcastCtrl_t             ctrl,
  input  logic [LANE_BITS-1:0]   inElem,
  input  logic [SCALE_W-1:0]     inScale,
  input  logic                   inQuad,
  output logic [2*LANE_BITS-1:0] outData
);

  localparam int NUM_SCALES = 1 << SCALE_W;

  logic [LANE_BITS-1:0]   repLane [NUM_SCALES];
  logic [LANE_BITS-1:0]   lowNext;
  logic [LANE_BITS-1:0]   highNext;
  logic [2*LANE_BITS-1:0] dataQ;

  // One replicated candidate per width; slicing drops the unused high bits.
  for (genvar s = 0; s < NUM_SCALES; s++) begin : g_width
    localparam int W    = MIN_BITS << s;
    localparam int REPS = LANE_BITS / W;
    assign repLane[s] = {REPS{inElem[W-1:0]}};
  end

  assign lowNext  = repLane[inScale];
  assign highNext = inQuad ? lowNext : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataQ <= '0;
    end else if (ctrl.capture) begin
      dataQ <= {highNext, lowNext};
    end
  end

  assign outData = dataQ;

  // Arithmetic model: masked element times a constant with a one per lane.
  function automatic logic [LANE_BITS-1:0] mulModel(
    input logic [LANE_BITS-1:0] elem,
    input logic [SCALE_W-1:0]   scale
  );
    int w;
    logic [LANE_BITS-1:0] mask;
    logic [LANE_BITS-1:0] k;
    w = MIN_BITS << scale;
    mask = '0;
    k = '0;
    for (int i = 0; i < LANE_BITS; i++) begin
      mask[i] = (i < w);
      if (i % w == 0) k[i] = 1'b1;
    end
    return (elem & mask) * k;
  endfunction

  logic [LANE_BITS-1:0] modelLow;
  assign modelLow = mulModel(inElem, inScale);

  assert_low_matches_product_R2: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.capture |=> (dataQ[LANE_BITS-1:0] == $past(modelLow)));

  assert_high_copy_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.capture && inQuad) |=> (dataQ[2*LANE_BITS-1:LANE_BITS] == dataQ[LANE_BITS-1:0]));

  assert_high_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.capture && !inQuad) |=> (dataQ[2*LANE_BITS-1:LANE_BITS] == '0));

endmodule

// File: rtl/lane_bcast.sv
module lane_bcast
  import lane_bcast_pkg::*;
#(
  parameter int MIN_BITS  = 8,
  parameter int SCALE_W   = 2,
  parameter int LANE_BITS = MIN_BITS << ((1 << SCALE_W) - 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   inValid,
  output logic                   inReady,
  input  logic [LANE_BITS-1:0]   inElem,
  input  logic [SCALE_W-1:0]     inScale,
  input  logic                   inQuad,
  output logic                   outValid,
  input  logic                   outReady,
  output logic [2*LANE_BITS-1:0] outData
);

  bcastCtrl_t ctrl;

  lane_bcast_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inReady  (inReady),
    .outValid (outValid),
    .outReady (outReady),
    .ctrl     (ctrl)
  );

  lane_bcast_dp #(
    .MIN_BITS  (MIN_BITS),
    .SCALE_W   (SCALE_W),
    .LANE_BITS (LANE_BITS)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .inElem  (inElem),
    .inScale (inScale),
    .inQuad  (inQuad),
    .outData (outData)
  );

  assert_held_data_stable_R10: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> $stable(outData));

endmodule

// File: tb/lane_bcast_test.sv
`timescale 1ns/1ps
module lane_bcast_test;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic         inReady;
  logic [63:0]  inElem = '0;
  logic [1:0]   inScale = '0;
  logic         inQuad = 1'b0;
  logic         outValid;
  logic         outReady = 1'b1;
  logic [127:0] outData;

  always #2 clk = ~clk;   // 250 MHz

  lane_bcast uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inElem(inElem), .inScale(inScale), .inQuad(inQuad),
    .outValid(outValid), .outReady(outReady), .outData(outData)
  );

  logic [127:0] expQ[$];
  string        tagQ[$];
  int  vecs = 0;
  int  errs = 0;
  int  cyc = 0;
  bit  randReady = 1'b0;
  bit  done = 1'b0;

  always @(posedge clk) cyc++;

  function automatic logic [127:0] expectOf(logic [63:0] e, logic [1:0] s, logic q);
    logic [63:0] lo;
    case (s)
      2'd0: lo = {56'd0, e[7:0]}  * 64'h0101010101010101;
      2'd1: lo = {48'd0, e[15:0]} * 64'h0001000100010001;
      2'd2: lo = {32'd0, e[31:0]} * 64'h0000000100000001;
      default: lo = e;
    endcase
    return {q ? lo : 64'd0, lo};
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [127:0] act, input logic [127:0] exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  endtask

  task automatic send(input logic [63:0] e, input logic [1:0] s,
                      input logic q, input string tag);
    bit ok;
    inElem = e; inScale = s; inQuad = q; inValid = 1'b1;
    do begin
      @(negedge clk);
      ok = inReady;
      @(posedge clk);
    end while (!ok);
    expQ.push_back(expectOf(e, s, q));
    tagQ.push_back(tag);
    #1 inValid = 1'b0;
  endtask

  // Monitor: compare each delivered result against the scoreboard.
  always @(negedge clk) begin : monitor
    logic [127:0] e;
    string t;
    if (rstN && outValid && outReady) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R9 output with no pending item", outData, '0);
      end else begin
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(outData === e, t, outData, e);
      end
    end
  end

  always @(posedge clk) begin
    if (randReady) begin
      #1 outReady = ($urandom_range(0, 3) != 0);
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog expired", '0, '0);
    finishRun();
  end

  initial begin : stim
    logic [127:0] held;
    int c0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(outValid === 1'b0, "R1 outValid after reset", {127'd0, outValid}, '0);
    check(inReady === 1'b1, "R1 inReady after reset", {127'd0, inReady}, 128'd1);
    @(posedge clk); #1 rstN = 1'b1;
    repeat (2) @(posedge clk); #1;

    // R9: latency of one edge
    send(64'hFFFF_FFFF_FFFF_FFA5, 2'd0, 1'b1, "R2 byte lanes, quad");
    @(negedge clk);
    check(outValid === 1'b1, "R9 valid right after accept", {127'd0, outValid}, 128'd1);
    @(posedge clk); #1;

    // Width and half-fill cases, junk in upper bits for R6
    send(64'h1234_5678_9ABC_DE3C, 2'd0, 1'b0, "R2 R6 R8 byte lanes, upper bits ignored");
    send(64'hDEAD_BEEF_CAFE_8001, 2'd1, 1'b1, "R3 R6 R7 halfword lanes");
    send(64'h0000_0000_0000_7FFE, 2'd1, 1'b0, "R3 R8 halfword lanes, half fill");
    send(64'hFFFF_FFFF_8765_4321, 2'd2, 1'b1, "R4 R6 R7 word lanes");
    send(64'hA5A5_A5A5_0000_0001, 2'd2, 1'b0, "R4 R8 word lanes, half fill");
    send(64'h0123_4567_89AB_CDEF, 2'd3, 1'b1, "R5 R7 doubleword pass-through");
    send(64'hFEDC_BA98_7654_3210, 2'd3, 1'b0, "R5 R8 doubleword, upper zero");
    send(64'hFFFF_FFFF_FFFF_FF00, 2'd0, 1'b1, "R6 zero byte with ones above");
    repeat (3) @(posedge clk); #1;

    // R10: stall holds valid, data and blocks input
    outReady = 1'b0;
    send(64'h0000_0000_0000_00C3, 2'd0, 1'b1, "R10 result released after stall");
    held = expectOf(64'h0000_0000_0000_00C3, 2'd0, 1'b1);
    inElem = 64'h1111_2222_3333_4444; inScale = 2'd3; inValid = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(outValid === 1'b1, "R10 valid held", {127'd0, outValid}, 128'd1);
      check(outData === held, "R10 data held", outData, held);
      check(inReady === 1'b0, "R10 input blocked", {127'd0, inReady}, '0);
    end
    @(posedge clk); #1 inValid = 1'b0; outReady = 1'b1;
    repeat (3) @(posedge clk); #1;

    // R11: full throughput
    c0 = cyc;
    for (int i = 0; i < 5; i++)
      send({32'h5555_0000, 24'd0, 8'(i * 17 + 3)}, 2'(i % 4), 1'(i % 2), "R11 stream item");
    check((cyc - c0) == 5, "R11 one accept per edge", 128'(cyc - c0), 128'd5);

    // Random mix with a stalling consumer
    randReady = 1'b1;
    for (int i = 0; i < 60; i++)
      send({$urandom, $urandom}, 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
           "R2 R3 R4 R5 R7 R8 random item");
    @(posedge clk);
    randReady = 1'b0;
    #1 outReady = 1'b1;
    repeat (6) @(posedge clk);
    @(negedge clk);
    check(expQ.size() == 0, "R9 all items delivered", 128'(expQ.size()), '0);
    finishRun();
  end

endmodule